// File: doc/BRIEF.md
# Least-Attained-Service Request Scheduler

This block picks one request per cycle from a memory controller's request buffer. Threads that have received less memory service over time are favoured. Each thread has a counter. The counter advances in every cycle in which the controller reports that the thread has a request in service. At the end of each quantum the counter is folded into a smoothed running total per thread. The history weight sets how strongly earlier quanta count. The counter is then cleared.

After each quantum ends, a small sequencer orders the threads by their new totals, one thread per cycle. The full new order replaces the old one in a single step. Until then, arbitration keeps using the old order.

A request whose age exceeds the starvation threshold is granted before all others. Among the remaining requests, the ordering is:
1. thread rank;
2. whether the request hits the row already open in its bank;
3. age.

DRAM timing and coordination between controllers are outside this block.

Top module: `las_sched`

## Requirements
- R1: After reset every smoothed total is zero and the threads are ranked by ID: thread 0 is highest and thread NUM_THREADS-1 is lowest.
- R2: In each cycle where `svc_active[t]` is 1, the service counter of thread t goes up by one. The counter saturates at 2^CNT_W-1 and does not wrap.
- R3: A quantum lasts L cycles, where L is `quantum_len`. If `quantum_len` is 0, L is DEF_QLEN. Any length below NUM_THREADS+1 is raised to NUM_THREADS+1. The boundary falls in the last cycle of each quantum, and that cycle's service is counted in the quantum that is ending.
- R4: At a boundary, the total becomes floor((w*total + (16-w)*count)/16). Here w is `hist_weight`, read as a fraction in sixteenths, and count includes the boundary cycle. The counter then restarts at zero.
- R5: A lower total gives a higher rank, and equal totals are ordered by lower thread ID. The new ranking takes effect exactly NUM_THREADS cycles after the boundary edge. Until then the previous ranking stays in force.
- R6: A valid entry is starved when `req_age` is strictly greater than `starve_thresh`. If any valid entry is starved, the grant goes to a starved entry.
- R7: Among entries with the same starvation status, the entry whose thread has the higher rank wins.
- R8: When starvation status and rank are equal, a row hit wins. A row hit means `open_valid[bank]` is 1 and the row in `open_row` for that bank equals the entry's row.
- R9: When all of the above are equal, the larger `req_age` wins. If ages are also equal, the lowest entry index wins.
- R10: `grant_valid` is 1 exactly when at least one `req_valid` bit is 1. When it is 1, `grant_idx` names a valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_active | input | NUM_THREADS | Per-thread flag: the thread has a request in service this cycle |
| quantum_len | input | QL_W | Quantum length in cycles; 0 selects DEF_QLEN |
| hist_weight | input | 4 | History weight in sixteenths |
| starve_thresh | input | AGE_W | Age above which an entry is starved |
| req_valid | input | NUM_ENTRIES | Entry occupied |
| req_thread | input | NUM_ENTRIES*TID_W | Owning thread per entry |
| req_bank | input | NUM_ENTRIES*BANK_W | Target bank per entry |
| req_row | input | NUM_ENTRIES*ROW_W | Target row per entry |
| req_age | input | NUM_ENTRIES*AGE_W | Age per entry; larger is older |
| open_valid | input | NUM_BANKS | Bank has an open row |
| open_row | input | NUM_BANKS*ROW_W | Open row per bank |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | IDX_W | Index of the granted entry |

## Verification
The bench builds the block with 4 threads, 8 entries and 4 banks. It uses 12-bit service counters, a 13-bit quantum length and a default quantum of 24 cycles. These sizes let a single quantum run past the counter's 4095 limit, so saturation can be observed in the ranking that follows. They also make both the zero-length default and the minimum-length clamp reachable within a few dozen cycles. With four threads, every rank change plays out over a four-cycle sequencing window, and the bench checks the grant in every one of those cycles.

// File: rtl/las_pkg.sv
package las_pkg;
   localparam int unsigned LAS_WEIGHT_W   = 4;
   localparam int unsigned LAS_WEIGHT_ONE = 16;

   typedef enum logic [0:0] {
      RANK_IDLE = 1'b0,
      RANK_SORT = 1'b1
   } las_rank_state_e;
endpackage

// File: rtl/las_svc_track.sv
// Per-thread service counters, quantum timer and smoothed totals.
module las_svc_track
   import las_pkg::*;
#(
   parameter int unsigned NUM_THREADS  = 4,
   parameter int unsigned CNT_W        = 12,
   parameter int unsigned QL_W         = 13,
   parameter int unsigned DEF_QLEN     = 24,
   parameter bit          SVC_SATURATE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_THREADS-1:0]       svc_active,
   input  logic [QL_W-1:0]              quantum_len,
   input  logic [LAS_WEIGHT_W-1:0]      hist_weight,
   output logic                         boundary,
   output logic [NUM_THREADS*CNT_W-1:0] total_flat
);
   localparam int unsigned     SUM_W    = CNT_W + LAS_WEIGHT_W;
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [QL_W-1:0]  MIN_QLEN = QL_W'(NUM_THREADS + 1);
   localparam logic [QL_W-1:0]  DEF_Q    = QL_W'(DEF_QLEN);

   logic [QL_W-1:0] eff_len;
   logic [QL_W-1:0] qcnt_q;

   always_comb begin
      eff_len = (quantum_len == '0) ? DEF_Q : quantum_len;
      if (eff_len < MIN_QLEN) begin
         eff_len = MIN_QLEN;
      end
   end

   assign boundary = (qcnt_q >= (eff_len - QL_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt_q <= '0;
      end else if (boundary) begin
         qcnt_q <= '0;
      end else begin
         qcnt_q <= qcnt_q + QL_W'(1);
      end
   end

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] tot_q;
      logic [CNT_W-1:0] cnt_inc;
      logic [SUM_W-1:0] mix;

      if (SVC_SATURATE) begin : g_sat
         assign cnt_inc = (svc_active[t] && (cnt_q != CNT_MAX)) ? cnt_q + CNT_W'(1) : cnt_q;
      end else begin : g_wrap
         assign cnt_inc = svc_active[t] ? cnt_q + CNT_W'(1) : cnt_q;
      end

      assign mix = SUM_W'(hist_weight) * SUM_W'(tot_q)
                 + (SUM_W'(LAS_WEIGHT_ONE) - SUM_W'(hist_weight)) * SUM_W'(cnt_inc);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            tot_q <= '0;
         end else if (boundary) begin
            tot_q <= CNT_W'(mix >> LAS_WEIGHT_W);
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_inc;
         end
      end

      assign total_flat[t*CNT_W +: CNT_W] = tot_q;
   end
endmodule

// File: rtl/las_rank_sort.sv
// Sequential ranking: one thread's position per cycle, committed together.
module las_rank_sort
   import las_pkg::*;
#(
   parameter int unsigned NUM_THREADS = 4,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned TID_W       = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [NUM_THREADS*CNT_W-1:0] total_flat,
   output logic [NUM_THREADS*TID_W-1:0] prio_flat,
   output logic                         busy
);
   localparam logic [TID_W-1:0] LAST_IDX = TID_W'(NUM_THREADS - 1);

   las_rank_state_e  state_q;
   logic [TID_W-1:0] idx_q;
   logic [TID_W-1:0] shadow_q [NUM_THREADS];
   logic [TID_W-1:0] prio_q   [NUM_THREADS];
   logic [CNT_W-1:0] tot      [NUM_THREADS];
   logic [CNT_W-1:0] cur_tot;
   logic [TID_W-1:0] cand_prio;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_unpack
      assign tot[t] = total_flat[t*CNT_W +: CNT_W];
      assign prio_flat[t*TID_W +: TID_W] = prio_q[t];
   end

   assign cur_tot = tot[idx_q];

   always_comb begin
      int unsigned ahead;
      ahead = 0;
      for (int j = 0; j < NUM_THREADS; j++) begin
         if ((tot[j] < cur_tot) || ((tot[j] == cur_tot) && (TID_W'(j) < idx_q))) begin
            ahead = ahead + 1;
         end
      end
      cand_prio = TID_W'(NUM_THREADS - 1 - ahead);
   end

   assign busy = (state_q == RANK_SORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RANK_IDLE;
         idx_q   <= '0;
         for (int i = 0; i < NUM_THREADS; i++) begin
            shadow_q[i] <= '0;
            prio_q[i]   <= TID_W'(NUM_THREADS - 1 - i);
         end
      end else begin
         case (state_q)
            RANK_IDLE: begin
               if (start) begin
                  state_q <= RANK_SORT;
                  idx_q   <= '0;
               end
            end
            RANK_SORT: begin
               shadow_q[idx_q] <= cand_prio;
               if (idx_q == LAST_IDX) begin
                  for (int i = 0; i < NUM_THREADS; i++) begin
                     prio_q[i] <= (TID_W'(i) == idx_q) ? cand_prio : shadow_q[i];
                  end
                  state_q <= RANK_IDLE;
               end else begin
                  idx_q <= idx_q + TID_W'(1);
               end
            end
            default: state_q <= RANK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/las_grant_arb.sv
// Combinational pick: starved, then rank, then row hit, then age, then index.
module las_grant_arb #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned NUM_THREADS = 4,
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned ROW_W       = 8,
   parameter int unsigned AGE_W       = 8,
   parameter int unsigned TID_W       = 2,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned IDX_W       = 3
) (
   input  logic [NUM_ENTRIES-1:0]        req_valid,
   input  logic [NUM_ENTRIES*TID_W-1:0]  req_thread,
   input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
   input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
   input  logic [NUM_BANKS-1:0]          open_valid,
   input  logic [NUM_BANKS*ROW_W-1:0]    open_row,
   input  logic [AGE_W-1:0]              starve_thresh,
   input  logic [NUM_THREADS*TID_W-1:0]  prio_flat,
   output logic                          grant_valid,
   output logic [IDX_W-1:0]              grant_idx
);
   localparam int unsigned KEY_W = 1 + TID_W + 1 + AGE_W;

   logic [KEY_W-1:0] key [NUM_ENTRIES];

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_key
      logic [TID_W-1:0]  thr;
      logic [BANK_W-1:0] bnk;
      logic [ROW_W-1:0]  row;
      logic [AGE_W-1:0]  age;
      logic              starved;
      logic              hit;
      logic [TID_W-1:0]  prio;

      assign thr     = req_thread[e*TID_W +: TID_W];
      assign bnk     = req_bank[e*BANK_W +: BANK_W];
      assign row     = req_row[e*ROW_W +: ROW_W];
      assign age     = req_age[e*AGE_W +: AGE_W];
      assign starved = (age > starve_thresh);
      assign hit     = open_valid[bnk] && (open_row[bnk*ROW_W +: ROW_W] == row);
      assign prio    = prio_flat[thr*TID_W +: TID_W];
      assign key[e]  = {starved, prio, hit, age};
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      best        = '0;
      grant_valid = 1'b0;
      grant_idx   = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (req_valid[i] && (!grant_valid || (key[i] > best))) begin
            best        = key[i];
            grant_valid = 1'b1;
            grant_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/las_sched.sv
module las_sched
   import las_pkg::*;
#(
   parameter int unsigned NUM_THREADS  = 4,
   parameter int unsigned NUM_ENTRIES  = 8,
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned ROW_W        = 8,
   parameter int unsigned AGE_W        = 8,
   parameter int unsigned CNT_W        = 12,
   parameter int unsigned QL_W         = 13,
   parameter int unsigned DEF_QLEN     = 24,
   parameter bit          SVC_SATURATE = 1'b1,
   localparam int unsigned TID_W  = $clog2(NUM_THREADS),
   localparam int unsigned BANK_W = $clog2(NUM_BANKS),
   localparam int unsigned IDX_W  = $clog2(NUM_ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_THREADS-1:0]        svc_active,
   input  logic [QL_W-1:0]               quantum_len,
   input  logic [LAS_WEIGHT_W-1:0]       hist_weight,
   input  logic [AGE_W-1:0]              starve_thresh,
   input  logic [NUM_ENTRIES-1:0]        req_valid,
   input  logic [NUM_ENTRIES*TID_W-1:0]  req_thread,
   input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
   input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
   input  logic [NUM_BANKS-1:0]          open_valid,
   input  logic [NUM_BANKS*ROW_W-1:0]    open_row,
   output logic                          grant_valid,
   output logic [IDX_W-1:0]              grant_idx
);
   if ((NUM_THREADS < 2) || ((1 << TID_W) != NUM_THREADS)) begin : g_bad_threads
      $error("las_sched: NUM_THREADS must be a power of two, at least 2");
   end
   if ((NUM_BANKS < 2) || ((1 << BANK_W) != NUM_BANKS)) begin : g_bad_banks
      $error("las_sched: NUM_BANKS must be a power of two, at least 2");
   end
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("las_sched: NUM_ENTRIES must be at least 2");
   end
   if ((DEF_QLEN < NUM_THREADS + 1) || (DEF_QLEN >= (1 << QL_W))) begin : g_bad_qlen
      $error("las_sched: DEF_QLEN out of range");
   end
   if ((CNT_W < 2) || (QL_W < 3) || (AGE_W < 1) || (ROW_W < 1)) begin : g_bad_width
      $error("las_sched: widths too small");
   end

   logic                         q_boundary;
   logic                         sort_busy;
   logic [NUM_THREADS*CNT_W-1:0] total_flat;
   logic [NUM_THREADS*TID_W-1:0] rank_prio_flat;

   las_svc_track #(
      .NUM_THREADS (NUM_THREADS),
      .CNT_W       (CNT_W),
      .QL_W        (QL_W),
      .DEF_QLEN    (DEF_QLEN),
      .SVC_SATURATE(SVC_SATURATE)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .svc_active (svc_active),
      .quantum_len(quantum_len),
      .hist_weight(hist_weight),
      .boundary   (q_boundary),
      .total_flat (total_flat)
   );

   las_rank_sort #(
      .NUM_THREADS(NUM_THREADS),
      .CNT_W      (CNT_W),
      .TID_W      (TID_W)
   ) u_rank (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (q_boundary),
      .total_flat(total_flat),
      .prio_flat (rank_prio_flat),
      .busy      (sort_busy)
   );

   las_grant_arb #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .NUM_THREADS(NUM_THREADS),
      .NUM_BANKS  (NUM_BANKS),
      .ROW_W      (ROW_W),
      .AGE_W      (AGE_W),
      .TID_W      (TID_W),
      .BANK_W     (BANK_W),
      .IDX_W      (IDX_W)
   ) u_arb (
      .req_valid    (req_valid),
      .req_thread   (req_thread),
      .req_bank     (req_bank),
      .req_row      (req_row),
      .req_age      (req_age),
      .open_valid   (open_valid),
      .open_row     (open_row),
      .starve_thresh(starve_thresh),
      .prio_flat    (rank_prio_flat),
      .grant_valid  (grant_valid),
      .grant_idx    (grant_idx)
   );
endmodule

// File: rtl/las_sched_chk.sv
module las_sched_chk #(
   parameter int unsigned NUM_THREADS = 4,
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned AGE_W       = 8,
   parameter int unsigned TID_W       = 2,
   parameter int unsigned IDX_W       = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_ENTRIES-1:0]       req_valid,
   input logic [NUM_ENTRIES*AGE_W-1:0] req_age,
   input logic [AGE_W-1:0]             starve_thresh,
   input logic                         grant_valid,
   input logic [IDX_W-1:0]             grant_idx,
   input logic                         boundary,
   input logic                         sort_busy,
   input logic [NUM_THREADS*TID_W-1:0] prio_flat
);
   logic [NUM_ENTRIES-1:0] starved_vec;
   logic [NUM_THREADS-1:0] prio_seen;

   always_comb begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         starved_vec[e] = req_valid[e] && (req_age[e*AGE_W +: AGE_W] > starve_thresh);
      end
      prio_seen = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         prio_seen[prio_flat[t*TID_W +: TID_W]] = 1'b1;
      end
   end

   a_r10_grant_iff_request: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (|req_valid));

   a_r10_grant_names_valid: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> req_valid[grant_idx]);

   a_r6_starved_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|starved_vec) |-> starved_vec[grant_idx]);

   a_r5_rank_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(prio_seen) == NUM_THREADS);

   a_r5_rank_holds_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sort_busy) |-> $stable(prio_flat));

   a_r3_boundary_not_during_sort: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |-> !sort_busy);
endmodule

bind las_sched las_sched_chk #(
   .NUM_THREADS(NUM_THREADS),
   .NUM_ENTRIES(NUM_ENTRIES),
   .AGE_W      (AGE_W),
   .TID_W      (TID_W),
   .IDX_W      (IDX_W)
) u_las_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_age      (req_age),
   .starve_thresh(starve_thresh),
   .grant_valid  (grant_valid),
   .grant_idx    (grant_idx),
   .boundary     (q_boundary),
   .sort_busy    (sort_busy),
   .prio_flat    (rank_prio_flat)
);

// File: tb/test_las_sched.sv
`timescale 1ns/1ps
module test_las_sched;
   localparam int T      = 4;
   localparam int N      = 8;
   localparam int B      = 4;
   localparam int ROW_W  = 8;
   localparam int AGE_W  = 8;
   localparam int CNT_W  = 12;
   localparam int QL_W   = 13;
   localparam int DEFQ   = 24;
   localparam int TID_W  = 2;
   localparam int BANK_W = 2;
   localparam int IDX_W  = 3;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                  rst_n;
   logic [T-1:0]          svc_active;
   logic [QL_W-1:0]       quantum_len;
   logic [3:0]            hist_weight;
   logic [AGE_W-1:0]      starve_thresh;
   logic [N-1:0]          req_valid;
   logic [N*TID_W-1:0]    req_thread;
   logic [N*BANK_W-1:0]   req_bank;
   logic [N*ROW_W-1:0]    req_row;
   logic [N*AGE_W-1:0]    req_age;
   logic [B-1:0]          open_valid;
   logic [B*ROW_W-1:0]    open_row;
   logic                  grant_valid;
   logic [IDX_W-1:0]      grant_idx;

   las_sched #(
      .NUM_THREADS(T), .NUM_ENTRIES(N), .NUM_BANKS(B), .ROW_W(ROW_W),
      .AGE_W(AGE_W), .CNT_W(CNT_W), .QL_W(QL_W), .DEF_QLEN(DEFQ)
   ) i_las_sched (
      .clk(clk), .rst_n(rst_n), .svc_active(svc_active), .quantum_len(quantum_len),
      .hist_weight(hist_weight), .starve_thresh(starve_thresh), .req_valid(req_valid),
      .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
      .open_valid(open_valid), .open_row(open_row), .grant_valid(grant_valid),
      .grant_idx(grant_idx)
   );

   // stimulus state
   bit e_v [N];
   int e_th[N], e_bk[N], e_rw[N], e_ag[N];
   bit o_v [B];
   int o_rw[B];
   bit s_svc[T];
   int s_ql, s_w, s_thr;

   // reference model state
   int m_q, m_pend;
   int m_cnt[T], m_tot[T], m_prio[T], m_new[T];

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   task automatic clear_reqs();
      for (int i = 0; i < N; i++) begin
         e_v[i] = 1'b0; e_th[i] = 0; e_bk[i] = 0; e_rw[i] = 0; e_ag[i] = 0;
      end
      for (int b = 0; b < B; b++) begin
         o_v[b] = 1'b0; o_rw[b] = 0;
      end
   endtask

   task automatic set_req(int i, int th, int bk, int rw, int ag);
      e_v[i] = 1'b1; e_th[i] = th; e_bk[i] = bk; e_rw[i] = rw; e_ag[i] = ag;
   endtask

   task automatic drive();
      for (int t = 0; t < T; t++) svc_active[t] = s_svc[t];
      quantum_len   = QL_W'(s_ql);
      hist_weight   = 4'(s_w);
      starve_thresh = AGE_W'(s_thr);
      for (int i = 0; i < N; i++) begin
         req_valid[i]                    = e_v[i];
         req_thread[i*TID_W +: TID_W]    = TID_W'(e_th[i]);
         req_bank[i*BANK_W +: BANK_W]    = BANK_W'(e_bk[i]);
         req_row[i*ROW_W +: ROW_W]       = ROW_W'(e_rw[i]);
         req_age[i*AGE_W +: AGE_W]       = AGE_W'(e_ag[i]);
      end
      for (int b = 0; b < B; b++) begin
         open_valid[b]              = o_v[b];
         open_row[b*ROW_W +: ROW_W] = ROW_W'(o_rw[b]);
      end
   endtask

   task automatic model_reset();
      m_q = 0; m_pend = 0;
      for (int t = 0; t < T; t++) begin
         m_cnt[t] = 0; m_tot[t] = 0; m_prio[t] = T - 1 - t; m_new[t] = 0;
      end
   endtask

   // R6 R7 R8 R9 R10: priority chain over the request buffer
   function automatic void model_grant(output bit ev, output int ei);
      int bs, bp, bh, ba;
      ev = 1'b0; ei = 0; bs = 0; bp = 0; bh = 0; ba = 0;
      for (int i = 0; i < N; i++) begin
         if (e_v[i]) begin
            int s, p, h, a;
            bit better;
            s = (e_ag[i] > s_thr) ? 1 : 0;
            p = m_prio[e_th[i]];
            h = (o_v[e_bk[i]] && (o_rw[e_bk[i]] == e_rw[i])) ? 1 : 0;
            a = e_ag[i];
            if (!ev)          better = 1'b1;
            else if (s != bs) better = (s > bs);
            else if (p != bp) better = (p > bp);
            else if (h != bh) better = (h > bh);
            else              better = (a > ba);
            if (better) begin
               ev = 1'b1; ei = i; bs = s; bp = p; bh = h; ba = a;
            end
         end
      end
   endfunction

   // R2 R3 R4 R5: counters, quantum, smoothing and delayed ranking
   task automatic model_edge();
      int eff;
      int c[T];
      eff = (s_ql == 0) ? DEFQ : s_ql;
      if (eff < T + 1) eff = T + 1;
      for (int t = 0; t < T; t++) begin
         c[t] = m_cnt[t] + (s_svc[t] ? 1 : 0);
         if (c[t] > CMAX) c[t] = CMAX;
      end
      if (m_pend > 0) begin
         m_pend--;
         if (m_pend == 0) begin
            for (int t = 0; t < T; t++) m_prio[t] = m_new[t];
         end
      end
      if (m_q >= eff - 1) begin
         for (int t = 0; t < T; t++) begin
            m_tot[t] = (s_w * m_tot[t] + (16 - s_w) * c[t]) / 16;
            m_cnt[t] = 0;
         end
         for (int t = 0; t < T; t++) begin
            int ahead;
            ahead = 0;
            for (int j = 0; j < T; j++) begin
               if (m_tot[j] < m_tot[t] || (m_tot[j] == m_tot[t] && j < t)) ahead++;
            end
            m_new[t] = T - 1 - ahead;
         end
         m_q    = 0;
         m_pend = T;
      end else begin
         for (int t = 0; t < T; t++) m_cnt[t] = c[t];
         m_q++;
      end
   endtask

   task automatic step(string tag);
      bit ev;
      int ei;
      @(negedge clk);
      drive();
      #2;
      model_grant(ev, ei);
      n_vec++;
      if ((grant_valid !== ev) || (ev && (grant_idx !== IDX_W'(ei)))) begin
         n_bad++;
         $display("FAIL %s: grant_valid=%0b grant_idx=%0d, expected valid=%0b idx=%0d",
                  tag, grant_valid, grant_idx, ev, ei);
      end
      if (rst_n) model_edge();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      clear_reqs();
      for (int t = 0; t < T; t++) s_svc[t] = 1'b0;
      s_ql = 0; s_w = 8; s_thr = 255;
      model_reset();
      rst_n = 1'b0;
      drive();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: empty buffer gives no grant
      repeat (3) step("R10");
      // R1: equal totals after reset, thread 0 ranked highest
      set_req(0, 3, 0, 5, 10); set_req(1, 2, 1, 5, 10);
      set_req(2, 1, 2, 5, 10); set_req(3, 0, 3, 5, 10);
      repeat (4) step("R1");

      // R5: thread 0 heavy, thread 2 half, ranking moves after each quantum
      s_ql = 8; s_w = 8;
      for (int k = 0; k < 40; k++) begin
         s_svc[0] = 1'b1; s_svc[2] = k[0];
         step("R5");
      end
      // R4: history weight high then zero
      s_svc[0] = 1'b0; s_svc[2] = 1'b0; s_svc[1] = 1'b1; s_w = 15;
      repeat (40) step("R4");
      s_w = 0;
      repeat (20) step("R4");

      // R3: default length then clamped length
      s_ql = 0; s_w = 6;
      for (int k = 0; k < 60; k++) begin
         for (int t = 0; t < T; t++) s_svc[t] = 1'($urandom_range(1));
         step("R3");
      end
      s_ql = 2;
      for (int k = 0; k < 30; k++) begin
         for (int t = 0; t < T; t++) s_svc[t] = 1'($urandom_range(1));
         step("R3");
      end

      // R6: starvation overrides rank
      for (int t = 0; t < T; t++) s_svc[t] = 1'b0;
      s_ql = 200;
      clear_reqs(); s_thr = 100;
      for (int t = 0; t < T; t++) set_req(t, t, t, 1, 50);
      set_req(4, 3, 0, 2, 200);
      repeat (2) step("R6");
      e_ag[4] = 100;
      repeat (2) step("R6");
      set_req(4, 2, 0, 2, 101); set_req(5, 1, 1, 2, 150);
      repeat (2) step("R6");

      // R8: row hit among same-thread entries
      clear_reqs(); s_thr = 255;
      set_req(0, 2, 1, 3, 90); set_req(1, 2, 1, 7, 20);
      o_v[1] = 1'b1; o_rw[1] = 7;
      repeat (2) step("R8");
      o_v[1] = 1'b0;
      repeat (2) step("R8");
      o_v[1] = 1'b1; o_rw[1] = 9;
      repeat (2) step("R8");

      // R9: age, then lowest index
      clear_reqs();
      set_req(2, 1, 0, 4, 30); set_req(5, 1, 2, 4, 70); set_req(6, 1, 3, 4, 70);
      repeat (2) step("R9");
      e_ag[5] = 69;
      repeat (2) step("R9");

      // R7: rank outranks hit and age
      clear_reqs();
      for (int t = 0; t < T; t++) begin
         set_req(t, t, t, 10 + t, 20 + 30 * t);
         o_v[t] = 1'b1; o_rw[t] = 10 + t;
      end
      set_req(4, 0, 0, 99, 1);
      repeat (4) step("R7");

      // R2: a long quantum saturates thread 0's counter
      clear_reqs();
      set_req(0, 0, 0, 1, 40); set_req(1, 1, 1, 1, 40);
      s_ql = 5000; s_w = 0; s_thr = 255;
      for (int t = 0; t < T; t++) s_svc[t] = 1'b0;
      for (int k = 0; k < 5030; k++) begin
         s_svc[0] = 1'b1;
         s_svc[1] = (k < 1000);
         step("R2");
      end

      // R10: mixed traffic with gaps
      s_ql = 7; s_w = $urandom_range(15); s_thr = 150;
      for (int k = 0; k < 400; k++) begin
         for (int t = 0; t < T; t++) s_svc[t] = 1'($urandom_range(1));
         clear_reqs();
         if ((k % 10) != 0) begin
            for (int i = 0; i < N; i++) begin
               if ($urandom_range(2) != 0) begin
                  set_req(i, $urandom_range(T - 1), $urandom_range(B - 1),
                          $urandom_range(3), $urandom_range(200));
               end
            end
            for (int b = 0; b < B; b++) begin
               o_v[b] = 1'($urandom_range(1)); o_rw[b] = $urandom_range(3);
            end
         end
         step("R10");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule